// File: doc/BRIEF.md
# Prioritised Interrupt Level Encoder with Acknowledge Decode

This block sits between up to seven interrupting peripherals and a processor. Each peripheral raises its own request line. The block encodes the most urgent pending request into a three-bit level code for the processor. It also compares that level against the processor's current service mask and asserts a take signal when the request is allowed to interrupt. When the processor answers with an acknowledge bus cycle, the block turns that cycle into a single per-level strobe. The strobe picks the peripheral that will then supply its vector.

An acknowledge cycle is recognised from the function-code bus. The level being acknowledged comes from three address bits. The level in a cycle is latched at the cycle's first clock and held until the bus cycle ends. The top level is non-maskable. Lower levels interrupt only when strictly above the mask. Vector supply and stacking belong to other logic.

Control is a three-state machine:
- ST_IDLE means nothing may interrupt.
- ST_REQ means a takeable request is presented.
- ST_ACK means an acknowledge cycle is in progress.

Transitions:
- From ST_IDLE or ST_REQ, a valid acknowledge cycle moves the machine to ST_ACK. Otherwise the machine goes to ST_REQ when a takeable request exists, and to ST_IDLE when none does.
- ST_ACK stays in ST_ACK while the acknowledge cycle lasts. When the cycle ends, it returns to ST_REQ or ST_IDLE by the same take rule.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `ipl` is 0, `int_take` is 0 and `ack_stb` is all zero.
- R2: One clock after the inputs are sampled, `ipl` equals the number of the highest set request line. Bit i of `irq_req` is level i+1. `ipl` is 0 when no line is set.
- R3: Levels 1 to 6 assert `int_take` one clock later only when the level is strictly greater than `mask_lvl`. An equal or lower level never asserts it.
- R4: Level 7 asserts `int_take` whatever the mask, including a mask of 7.
- R5: An acknowledge cycle exists only when `bus_cyc` is 1 and `fc` is 3'b111. Any other combination gives no strobe.
- R6: An acknowledge cycle with `addr_lvl` from 1 to 7 sets exactly bit `addr_lvl`-1 of `ack_stb` from the next clock. `addr_lvl` of 0 sets no strobe.
- R7: While a strobe is active, `int_take` is 0. When the acknowledge cycle ends, `ack_stb` clears on the next clock and `int_take` again follows R3 and R4.
- R8: Within one acknowledge cycle the strobe keeps the level latched at the cycle's start, even if `addr_lvl` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 7 | Request lines, bit i is level i+1 |
| mask_lvl | input | 3 | Processor's current service mask |
| bus_cyc | input | 1 | Processor bus cycle active |
| fc | input | 3 | Function code of the bus cycle |
| addr_lvl | input | 3 | Address bits carrying the acknowledged level |
| ipl | output | 3 | Encoded highest pending level |
| int_take | output | 1 | Pending level may interrupt now |
| ack_stb | output | 7 | Per-level acknowledge strobes, bit i is level i+1 |

## Verification
The bench drives a level equal to the mask. A design that compared with greater-or-equal would take it. It drives level 7 against a mask of 7. A design that treated the top level as maskable would drop it. It drives a function code one bit short of the acknowledge code and an acknowledge with level 0. A loose decoder would fire a strobe in either case. It also changes the address in the middle of an acknowledge. A decoder that did not latch the level would move the strobe, or pulse two strobes.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_ACK  = 2'd2
    } irq_state_e;
endpackage

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder #(
    parameter int NUM_LVL = 7,
    parameter int LVL_W   = $clog2(NUM_LVL + 1)
) (
    input  logic [NUM_LVL-1:0] req,
    output logic [LVL_W-1:0]   lvl
);
    always_comb begin
        lvl = '0;
        for (int i = 0; i < NUM_LVL; i++) begin
            if (req[i]) lvl = LVL_W'(i + 1);
        end
    end
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
    parameter int NUM_LVL = 7,
    parameter int LVL_W   = $clog2(NUM_LVL + 1)
) (
    input  logic [LVL_W-1:0] lvl,
    input  logic [LVL_W-1:0] mask,
    output logic             take
);
    localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(NUM_LVL);

    always_comb begin
        take = (lvl != '0) && ((lvl == NMI_LVL) || (lvl > mask));
    end
endmodule

// File: rtl/irq_ack_decoder.sv
module irq_ack_decoder #(
    parameter int NUM_LVL = 7,
    parameter int LVL_W   = $clog2(NUM_LVL + 1),
    parameter int FC_W    = 3
) (
    input  logic               bus_cyc,
    input  logic [FC_W-1:0]    fc,
    input  logic [LVL_W-1:0]   addr_lvl,
    input  logic               active,
    input  logic [LVL_W-1:0]   lvl_q,
    output logic               ack_cycle,
    output logic               ack_valid,
    output logic [NUM_LVL-1:0] stb
);
    localparam logic [FC_W-1:0]  FC_ACK  = '1;
    localparam logic [LVL_W-1:0] MAX_LVL = LVL_W'(NUM_LVL);

    always_comb begin
        ack_cycle = bus_cyc && (fc == FC_ACK);
        ack_valid = ack_cycle && (addr_lvl != '0) && (addr_lvl <= MAX_LVL);
    end

    for (genvar g = 0; g < NUM_LVL; g++) begin : g_stb
        assign stb[g] = active && (lvl_q == LVL_W'(g + 1));
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int NUM_LVL = 7,
    parameter int FC_W    = 3,
    localparam int LVL_W  = $clog2(NUM_LVL + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LVL-1:0] irq_req,
    input  logic [LVL_W-1:0]   mask_lvl,
    input  logic               bus_cyc,
    input  logic [FC_W-1:0]    fc,
    input  logic [LVL_W-1:0]   addr_lvl,
    output logic [LVL_W-1:0]   ipl,
    output logic               int_take,
    output logic [NUM_LVL-1:0] ack_stb
);
    import irq_pkg::*;

    localparam logic [LVL_W-1:0] NMI_LVL = LVL_W'(NUM_LVL);
    localparam logic [FC_W-1:0]  FC_ACK  = '1;

    irq_state_e         state_q, state_d;
    logic [LVL_W-1:0]   ack_lvl_q, ack_lvl_d;
    logic [LVL_W-1:0]   ipl_q;
    logic [LVL_W-1:0]   enc_lvl;
    logic               take_ok;
    logic               ack_cycle, ack_valid;
    logic [NUM_LVL-1:0] stb_w;

    irq_prio_encoder #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_enc (
        .req (irq_req),
        .lvl (enc_lvl)
    );

    irq_mask_gate #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W)) u_gate (
        .lvl  (enc_lvl),
        .mask (mask_lvl),
        .take (take_ok)
    );

    irq_ack_decoder #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .FC_W(FC_W)) u_ackdec (
        .bus_cyc   (bus_cyc),
        .fc        (fc),
        .addr_lvl  (addr_lvl),
        .active    (state_q == ST_ACK),
        .lvl_q     (ack_lvl_q),
        .ack_cycle (ack_cycle),
        .ack_valid (ack_valid),
        .stb       (stb_w)
    );

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        ack_lvl_d = ack_lvl_q;
        unique case (state_q)
            ST_IDLE, ST_REQ: begin
                if (ack_valid) begin
                    state_d   = ST_ACK;
                    ack_lvl_d = addr_lvl;
                end else begin
                    state_d = take_ok ? ST_REQ : ST_IDLE;
                end
            end
            ST_ACK: begin
                if (!ack_cycle) state_d = take_ok ? ST_REQ : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            ack_lvl_q <= '0;
            ipl_q     <= '0;
        end else begin
            state_q   <= state_d;
            ack_lvl_q <= ack_lvl_d;
            ipl_q     <= enc_lvl;
        end
    end

    // Outputs
    always_comb begin
        ipl      = ipl_q;
        int_take = (state_q == ST_REQ);
        ack_stb  = stb_w;
    end

    a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_stb))
        else $error("a_r6_one_strobe");

    a_r5_strobe_needs_ack_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb != '0) |-> $past(bus_cyc && (fc == FC_ACK)))
        else $error("a_r5_strobe_needs_ack_cycle");

    a_r3_take_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        int_take |-> ((ipl != '0) && ((ipl == NMI_LVL) || (ipl > $past(mask_lvl)))))
        else $error("a_r3_take_above_mask");

    a_r7_no_take_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb != '0) |-> !int_take)
        else $error("a_r7_no_take_in_ack");

    a_r8_strobe_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((ack_stb != '0) && ($past(ack_stb) != '0)) |-> $stable(ack_stb))
        else $error("a_r8_strobe_held");
endmodule

// File: tb/irq_prio_ctrl_test.sv
module irq_prio_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] irq_req = '0;
    logic [2:0] mask_lvl = '0;
    logic       bus_cyc = 1'b0;
    logic [2:0] fc = '0;
    logic [2:0] addr_lvl = '0;
    logic [2:0] ipl;
    logic       int_take;
    logic [6:0] ack_stb;

    int checks = 0;
    int failures = 0;

    // model state: 0 idle, 1 request, 2 acknowledge
    int         m_st = 0;
    logic [2:0] m_lvl = '0;
    logic [2:0] m_ipl = '0;

    always #10 clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .mask_lvl(mask_lvl),
        .bus_cyc(bus_cyc), .fc(fc), .addr_lvl(addr_lvl),
        .ipl(ipl), .int_take(int_take), .ack_stb(ack_stb)
    );

    function automatic logic [2:0] top_level(input logic [6:0] r);
        logic [2:0] h = '0;
        for (int i = 1; i <= 7; i++) if (r[i-1]) h = 3'(i);
        return h;
    endfunction

    function automatic logic may_take(input logic [6:0] r, input logic [2:0] m);
        logic [2:0] h = top_level(r);
        return (h != 0) && ((h == 3'd7) || (h > m));
    endfunction

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
        end
    endtask

    task automatic step(input logic [6:0] r, input logic [2:0] m, input logic c,
                        input logic [2:0] f, input logic [2:0] a, input string tag);
        logic ack;
        logic tk;
        @(negedge clk);
        irq_req = r; mask_lvl = m; bus_cyc = c; fc = f; addr_lvl = a;
        ack = c && (f == 3'b111);
        tk  = may_take(r, m);
        @(posedge clk);
        m_ipl = top_level(r);
        if (m_st != 2) begin
            if (ack && a != 0) begin m_st = 2; m_lvl = a; end
            else m_st = tk ? 1 : 0;
        end else if (!ack) begin
            m_st = tk ? 1 : 0;
        end
        #1;
        check(tag, "ipl", int'(ipl), int'(m_ipl));
        check(tag, "int_take", int'(int_take), (m_st == 1) ? 1 : 0);
        check(tag, "ack_stb", int'(ack_stb), (m_st == 2) ? int'(7'(1) << (m_lvl - 1)) : 0);
    endtask

    initial begin
        #3_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        check("R1", "ipl", int'(ipl), 0);
        check("R1", "int_take", int'(int_take), 0);
        check("R1", "ack_stb", int'(ack_stb), 0);
        @(negedge clk);
        rst_n = 1'b1;

        step(7'b0000000, 3'd0, 1'b0, 3'd0, 3'd0, "R1");
        step(7'b0000101, 3'd0, 1'b0, 3'd0, 3'd0, "R2");
        step(7'b1000000, 3'd7, 1'b0, 3'd0, 3'd0, "R4");
        step(7'b0100000, 3'd7, 1'b0, 3'd0, 3'd0, "R3");
        step(7'b0000100, 3'd3, 1'b0, 3'd0, 3'd0, "R3");
        step(7'b0000100, 3'd2, 1'b0, 3'd0, 3'd0, "R3");
        step(7'b0000100, 3'd2, 1'b1, 3'd6, 3'd3, "R5");
        step(7'b0000100, 3'd2, 1'b0, 3'd7, 3'd3, "R5");
        step(7'b0000100, 3'd2, 1'b1, 3'd7, 3'd0, "R6");
        step(7'b0000100, 3'd2, 1'b1, 3'd7, 3'd3, "R6");
        step(7'b0000100, 3'd2, 1'b1, 3'd7, 3'd5, "R8");
        step(7'b0000100, 3'd2, 1'b0, 3'd0, 3'd5, "R7");
        step(7'b1000001, 3'd7, 1'b1, 3'd7, 3'd7, "R6");
        step(7'b1000001, 3'd7, 1'b0, 3'd0, 3'd0, "R7");

        for (int n = 0; n < 500; n++) begin
            logic [2:0] f;
            f = ($urandom % 2) ? 3'd7 : 3'($urandom % 8);
            step(7'($urandom), 3'($urandom), 1'($urandom % 3 != 0), f, 3'($urandom), "R2");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule